// File: doc/BRIEF.md
# Three-Variable Fixed-Polarity Reed-Muller Minimizer

This block takes the complete truth vector of a three-input Boolean function and returns the cheapest two-level AND-EXOR form in which each variable keeps one fixed polarity. Every variable is used either always true or always complemented, so there are eight candidate polarity vectors. Each candidate has its own canonical coefficient vector.

All eight candidates are formed side by side in combinational logic. Each one is an index-permuted copy of the truth vector passed through a three-stage XOR butterfly. The nonzero coefficients of each candidate are counted, and a comparison chain picks the candidate with the smallest count. The answer is registered on the clock edge at which `in_valid` is high, so the latency is the same for every function. Downstream logic reads the winning polarity, its coefficients and its product count as one registered word marked by `out_valid`.

Top module: `fprm_min_top`

## Requirements
- R1: Polarity bit i of `best_pol` set to 0 means variable x_i appears uncomplemented, and set to 1 means it appears as ~x_i. The input minterm index is m = {x2,x1,x0}, and bit m of `truth_in` is the function value there. Evaluating the reported expression at every input point reproduces `truth_in`.
- R2: Bit s of `best_coef` is the coefficient of the product of the literals of the variables whose index bits are set in s. Bit 0 is the constant term and bit 7 is the triple product. The vector is the one canonical form for the reported polarity.
- R3: `best_cnt` is the smallest number of product terms found over all eight polarity vectors.
- R4: When several polarities reach the minimum count, the numerically lowest polarity vector is reported.
- R5: `best_cnt` equals the number of set bits in `best_coef` and lies between 0 and 8.
- R6: The constant-0 function gives polarity 0, coefficients 0x00 and count 0. The constant-1 function gives polarity 0, coefficients 0x01 and count 1.
- R7: A function presented with `in_valid` high at a rising edge appears on the outputs right after that edge. `out_valid` is high exactly in the cycle after each edge at which `in_valid` was high.
- R8: At an edge where `in_valid` is low, the result outputs keep their previous values whatever `truth_in` carries.
- R9: Synchronous active-low reset clears `out_valid`, `best_pol`, `best_coef` and `best_cnt` to zero.
- R10: The constant coefficient equals `truth_in` at minterm index `best_pol`. The triple-product coefficient equals the XOR of all eight truth bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Capture strobe for `truth_in` |
| truth_in | input | 8 | Truth vector, bit m is f at minterm m |
| out_valid | output | 1 | Result registers were loaded at the last edge |
| best_pol | output | 3 | Winning polarity vector |
| best_coef | output | 8 | Coefficient vector for the winning polarity |
| best_cnt | output | 4 | Number of product terms of the winner |

## Verification
The checker watches four things on every cycle:
- the one-cycle relation between `in_valid` and `out_valid`;
- that results hold when no capture happens;
- that the count agrees with the ones in the coefficient vector, together with the zero-count case;
- that the constant and triple-product coefficients agree with the captured truth vector.

Only the bench scenarios can show that the count is truly minimal, that ties go to the lowest polarity, and that the expression expands back to the function. The bench shows this by sweeping all 256 functions against an independent subset-sum model, and by reset in the middle of a run.

// File: rtl/fprm_pkg.sv
// Package: shared sizing for the fixed-polarity minimizer.
// Assumes the variable count stays small, because every polarity is built in parallel.
package fprm_pkg;
    localparam int unsigned DEF_NV = 3;

    // Width needed to hold a count from 0 to n inclusive.
    function automatic int unsigned cnt_width(input int unsigned n);
        return $clog2(n + 1);
    endfunction
endpackage

// File: rtl/fprm_xform.sv
// Module: fprm_xform
// Builds the Reed-Muller coefficient vector for one fixed polarity POL.
// The truth index is first XOR-permuted by POL, then passed through NV in-place
// butterfly stages. Purely combinational.
module fprm_xform #(
    parameter int unsigned NV  = fprm_pkg::DEF_NV,
    parameter int unsigned POL = 0
) (
    input  logic [(1<<NV)-1:0] truth_i,
    output logic [(1<<NV)-1:0] coef_o
);
    localparam int unsigned NT = 1 << NV;

    // Permute by polarity, then run the XOR butterfly stage by stage.
    always_comb begin
        logic [NT-1:0] work;
        for (int m = 0; m < NT; m++) begin
            work[m] = truth_i[m ^ POL];
        end
        for (int k = 0; k < NV; k++) begin
            for (int m = 0; m < NT; m++) begin
                if (((m >> k) & 1) == 1) begin
                    work[m] = work[m] ^ work[m - (1 << k)];
                end
            end
        end
        coef_o = work;
    end
endmodule

// File: rtl/fprm_popcnt.sv
// Module: fprm_popcnt
// Counts the set bits of a W-bit vector. Assumes CW is wide enough for W.
module fprm_popcnt #(
    parameter int unsigned W  = 8,
    parameter int unsigned CW = 4
) (
    input  logic [W-1:0]  vec_i,
    output logic [CW-1:0] cnt_o
);
    // Adder chain over the vector bits.
    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < W; i++) begin
            cnt_o = cnt_o + CW'(vec_i[i]);
        end
    end
endmodule

// File: rtl/fprm_select.sv
// Module: fprm_select
// Chooses the polarity with the smallest product count.
// A strict less-than comparison keeps the earliest index, so ties go to the lowest polarity.
module fprm_select #(
    parameter int unsigned NV = fprm_pkg::DEF_NV,
    parameter int unsigned CW = 4
) (
    input  logic [(1<<NV)-1:0][CW-1:0]       cnt_i,
    input  logic [(1<<NV)-1:0][(1<<NV)-1:0]  coef_i,
    output logic [NV-1:0]                    pol_o,
    output logic [(1<<NV)-1:0]               coef_o,
    output logic [CW-1:0]                    cnt_o
);
    localparam int unsigned NT = 1 << NV;

    // Linear scan from polarity 0 upward, replacing only on a strict improvement.
    always_comb begin
        pol_o  = '0;
        coef_o = coef_i[0];
        cnt_o  = cnt_i[0];
        for (int p = 1; p < NT; p++) begin
            if (cnt_i[p] < cnt_o) begin
                pol_o  = NV'(p);
                coef_o = coef_i[p];
                cnt_o  = cnt_i[p];
            end
        end
    end
endmodule

// File: rtl/fprm_min_top.sv
// Module: fprm_min_top
// Evaluates every fixed-polarity Reed-Muller form of an NV-input function in parallel.
// Registers the cheapest one on an edge where in_valid is high, so the latency is one cycle.
// Assumes truth_in is stable around the capturing edge. Synchronous active-low reset.
module fprm_min_top #(
    parameter int unsigned NV = fprm_pkg::DEF_NV,
    localparam int unsigned NT = 1 << NV,
    localparam int unsigned CW = fprm_pkg::cnt_width(NT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [NT-1:0] truth_in,
    output logic          out_valid,
    output logic [NV-1:0] best_pol,
    output logic [NT-1:0] best_coef,
    output logic [CW-1:0] best_cnt
);
    logic [NT-1:0][NT-1:0] cand_coef;
    logic [NT-1:0][CW-1:0] cand_cnt;
    logic [NV-1:0]         win_pol;
    logic [NT-1:0]         win_coef;
    logic [CW-1:0]         win_cnt;

    // One transform and one counter per polarity vector.
    for (genvar p = 0; p < NT; p++) begin : g_pol
        fprm_xform #(.NV(NV), .POL(p)) u_xf (
            .truth_i (truth_in),
            .coef_o  (cand_coef[p])
        );
        fprm_popcnt #(.W(NT), .CW(CW)) u_pc (
            .vec_i (cand_coef[p]),
            .cnt_o (cand_cnt[p])
        );
    end

    fprm_select #(.NV(NV), .CW(CW)) u_sel (
        .cnt_i  (cand_cnt),
        .coef_i (cand_coef),
        .pol_o  (win_pol),
        .coef_o (win_coef),
        .cnt_o  (win_cnt)
    );

    // Result registers: load on in_valid, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            best_pol  <= '0;
            best_coef <= '0;
            best_cnt  <= '0;
        end else if (in_valid) begin
            best_pol  <= win_pol;
            best_coef <= win_coef;
            best_cnt  <= win_cnt;
        end
    end

    // Valid flag tracks the capture strobe by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end
endmodule

// File: rtl/fprm_min_chk.sv
// Module: fprm_min_chk
// Temporal checks on fprm_min_top, attached by bind. Only observes ports.
module fprm_min_chk #(
    parameter int unsigned NV = fprm_pkg::DEF_NV,
    localparam int unsigned NT = 1 << NV,
    localparam int unsigned CW = fprm_pkg::cnt_width(NT)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [NT-1:0] truth_in,
    input logic          out_valid,
    input logic [NV-1:0] best_pol,
    input logic [NT-1:0] best_coef,
    input logic [CW-1:0] best_cnt
);
    logic          armed;
    logic [NT-1:0] truth_q;

    // Marks that the previous edge was outside reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // Copy of the truth vector present at the previous edge.
    always_ff @(posedge clk) begin
        truth_q <= truth_in;
    end

    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (out_valid == $past(in_valid)));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(best_pol) && $stable(best_coef) && $stable(best_cnt)));

    p_cnt_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(best_coef) == int'(best_cnt)));

    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (int'(best_cnt) <= NT));

    p_zero_fn_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && best_cnt == '0) |-> (best_pol == '0));

    p_const_term_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (best_coef[0] == truth_q[best_pol]));

    p_top_term_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (best_coef[NT-1] == ^truth_q));
endmodule

bind fprm_min_top fprm_min_chk #(.NV(NV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .truth_in  (truth_in),
    .out_valid (out_valid),
    .best_pol  (best_pol),
    .best_coef (best_coef),
    .best_cnt  (best_cnt)
);

// File: tb/sim_fprm_min_top.sv
// Bench for fprm_min_top: a directed vector table, then a full sweep against a
// subset-sum model, then the hold, reset and mid-run reset cases.
module sim_fprm_min_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] truth_in = 8'h00;
    logic       out_valid;
    logic [2:0] best_pol;
    logic [7:0] best_coef;
    logic [3:0] best_cnt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fprm_min_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .truth_in  (truth_in),
        .out_valid (out_valid),
        .best_pol  (best_pol),
        .best_coef (best_coef),
        .best_cnt  (best_cnt)
    );

    // Each entry is {truth, polarity, coefficients, count}.
    localparam logic [22:0] TBL [8] = '{
        {8'h00, 3'd0, 8'h00, 4'd0},
        {8'hFF, 3'd0, 8'h01, 4'd1},
        {8'hAA, 3'd0, 8'h02, 4'd1},
        {8'h55, 3'd1, 8'h02, 4'd1},
        {8'h80, 3'd0, 8'h80, 4'd1},
        {8'h01, 3'd7, 8'h80, 4'd1},
        {8'h96, 3'd0, 8'h16, 4'd3},
        {8'hEE, 3'd3, 8'h09, 4'd2}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Coefficient s is the XOR of the permuted truth values over all submasks of s.
    function automatic logic [7:0] model_coef(input logic [7:0] t, input int p);
        logic [7:0] c;
        for (int s = 0; s < 8; s++) begin
            logic b;
            b = 1'b0;
            for (int m = 0; m < 8; m++) begin
                if ((m & ~s & 7) == 0) b = b ^ t[m ^ p];
            end
            c[s] = b;
        end
        return c;
    endfunction

    // Evaluates the expression with polarity p and coefficients c at point x.
    function automatic logic expand(input logic [7:0] c, input int p, input int x);
        logic v;
        v = 1'b0;
        for (int s = 0; s < 8; s++) begin
            logic term;
            term = c[s];
            for (int i = 0; i < 3; i++) begin
                if ((s >> i) & 1) term = term & (((x >> i) & 1) ^ ((p >> i) & 1));
            end
            v = v ^ term;
        end
        return v;
    endfunction

    // Presents one function for one edge, then samples after it.
    task automatic apply(input logic [7:0] t);
        @(negedge clk);
        truth_in = t;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin : main
        // R9: reset state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 out_valid in reset", int'(out_valid), 0);
        check("R9 best_coef in reset", int'(best_coef), 0);
        check("R9 best_cnt in reset", int'(best_cnt), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 no valid without strobe", int'(out_valid), 0);

        // Directed table (R1 R2 R3 R4 R6).
        for (int i = 0; i < 8; i++) begin
            apply(TBL[i][22:15]);
            check("R7 out_valid after capture", int'(out_valid), 1);
            check("R4 table polarity", int'(best_pol), int'(TBL[i][14:12]));
            check("R2 table coefficients", int'(best_coef), int'(TBL[i][11:4]));
            check("R3 table count", int'(best_cnt), int'(TBL[i][3:0]));
        end
        apply(8'h00);
        check("R6 zero function count", int'(best_cnt), 0);
        apply(8'hFF);
        check("R6 one function coef", int'(best_coef), 8'h01);

        // Full sweep against the model.
        for (int f = 0; f < 256; f++) begin
            int bp;
            int bn;
            logic [7:0] bc;
            bp = 0;
            bc = model_coef(8'(f), 0);
            bn = $countones(bc);
            for (int p = 1; p < 8; p++) begin
                logic [7:0] c;
                c = model_coef(8'(f), p);
                if ($countones(c) < bn) begin
                    bp = p;
                    bc = c;
                    bn = $countones(c);
                end
            end
            apply(8'(f));
            check("R3 minimal count", int'(best_cnt), bn);
            check("R4 lowest tied polarity", int'(best_pol), bp);
            check("R2 coefficient vector", int'(best_coef), int'(bc));
            check("R5 count equals ones", int'(best_cnt), $countones(best_coef));
            check("R10 constant term", int'(best_coef[0]), int'(f[int'(best_pol)]));
            for (int x = 0; x < 8; x++) begin
                check("R1 expansion matches truth",
                      int'(expand(best_coef, int'(best_pol), x)), int'(f[x]));
            end
        end

        // R8: a new truth vector without the strobe is ignored.
        apply(8'hEE);
        @(negedge clk);
        truth_in = 8'h01;
        @(posedge clk);
        @(negedge clk);
        check("R8 polarity held", int'(best_pol), 3);
        check("R8 coef held", int'(best_coef), 8'h09);
        check("R8 count held", int'(best_cnt), 2);
        check("R7 valid drops", int'(out_valid), 0);

        // R9: reset in the middle of a run wins over a capture.
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b1;
        truth_in = 8'h96;
        @(posedge clk);
        @(negedge clk);
        check("R9 mid-run valid cleared", int'(out_valid), 0);
        check("R9 mid-run coef cleared", int'(best_coef), 0);
        check("R9 mid-run pol cleared", int'(best_pol), 0);
        in_valid = 1'b0;
        rst_n = 1'b1;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule